// File: doc/BRIEF.md
# Log-Domain Operator Output Stage

This block sits at the end of one FM operator. It receives the log-sine attenuation for the current phase and the sign of the waveform. It also receives the total-level and envelope attenuations for the operator. All gain is applied by adding attenuations in the log domain. The block then turns the summed attenuation into a signed linear sample with an exponent table and a right shift.

Attenuation is counted in units of 1/256 of a 6 dB step, so 0x100 is 6 dB and 0x080 is 3 dB. The total level has eight fractional steps per 6 dB and is placed five bits up. The envelope has thirty-two fractional steps per 6 dB and is placed three bits up. The low eight bits of the summed attenuation select a mantissa from the exponent table. The upper bits give a right-shift count.

Negative samples are formed by inverting the magnitude bits. The output is therefore asymmetric by one count: a full-scale operator reaches +4084 and -4085. The block is a two-stage pipeline with a valid flag that travels alongside the data. It never stalls.

Top module: `lod_operator_out`

## Requirements
- R1: While reset is asserted, and after it is released until the first result arrives, `out_valid` is 0 and `out_sample` is 0.
- R2: A sample accepted with `in_valid` high at clock edge k appears with `out_valid` high after edge k+2. Each accepted input gives exactly one output cycle.
- R3: The summed attenuation is `in_logsin + in_tl*32 + in_env*8`, in units of 1/256 of 6 dB.
- R4: For a summed attenuation A, let i = A mod 256, s = A div 256 and T(i) = round(2^((255-i)/256)*1024) - 1024. The magnitude is ((T(i)+1024)*2) >> s. For example, A = 0 gives 4084 and A = 256 gives 2042.
- R5: When the shift count s is 13 or more, the magnitude is zero.
- R6: A summed attenuation above 8191 saturates to 8191. It never wraps, so it gives zero magnitude.
- R7: With `in_sign` = 1 the sample is the bitwise inverse of the magnitude, that is -(magnitude)-1. A zero magnitude therefore gives -1. Full scale is +4084 and -4085.
- R8: While `out_valid` is 0, `out_sample` holds its last value, whatever is applied on the inputs.
- R9: Inputs applied on consecutive cycles produce results on consecutive cycles, in order, with no loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_logsin | input | 12 | Log-sine attenuation from the phase path |
| in_sign | input | 1 | Waveform sign, 1 = negative |
| in_tl | input | 6 | Total-level attenuation |
| in_env | input | 9 | Envelope attenuation |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | 13 | Signed linear sample |

## Verification
The hardest case to reach from the ports is a sum that runs past the 13-bit attenuation range. Without saturation, the wrapped value would look like a loud sample. The stimulus reaches it by combining a near-maximum log-sine value with a full envelope and a small total level, so the sum lands just past the limit. Gaps in `in_valid` during which the inputs change show that the held sample is left alone. A sweep of all 256 table positions at zero shift, followed by a long run of back-to-back random inputs, checks the table and the pipeline ordering against a behavioural model.

// File: rtl/lod_pkg.sv
package lod_pkg;

   // Rounded table entry: 2^((top-i)/2^frac_w) scaled by 2^mant_w, minus the implied one.
   function automatic int exp_entry(input int i, input int frac_w, input int mant_w);
      real e;
      real v;
      e = real'((1 << frac_w) - 1 - i) / real'(1 << frac_w);
      v = (2.0 ** e) * real'(1 << mant_w);
      return $rtoi(v + 0.5) - (1 << mant_w);
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/lod_att_sum.sv
module lod_att_sum #(
   parameter int LS_W      = 12,
   parameter int TL_W      = 6,
   parameter int ENV_W     = 9,
   parameter int TL_SHIFT  = 5,
   parameter int ENV_SHIFT = 3,
   parameter int ATT_W     = 13,
   parameter bit SATURATE  = 1'b1
) (
   input  logic [LS_W-1:0]  logsin,
   input  logic [TL_W-1:0]  tl,
   input  logic [ENV_W-1:0] env,
   output logic [ATT_W-1:0] att
);
   localparam int SUM_W = lod_pkg::max3(LS_W, TL_W + TL_SHIFT, ENV_W + ENV_SHIFT) + 2;
   localparam logic [SUM_W-1:0] ATT_MAX = SUM_W'((1 << ATT_W) - 1);

   logic [SUM_W-1:0] sum_w;

   always_comb begin
      sum_w = SUM_W'(logsin)
            + (SUM_W'(tl)  << TL_SHIFT)
            + (SUM_W'(env) << ENV_SHIFT);
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb att = (sum_w > ATT_MAX) ? ATT_MAX[ATT_W-1:0] : sum_w[ATT_W-1:0];
      end else begin : g_wrap
         always_comb att = sum_w[ATT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/lod_exp_rom.sv
module lod_exp_rom #(
   parameter int FRAC_W = 8,
   parameter int MANT_W = 10
) (
   input  logic [FRAC_W-1:0] idx,
   output logic [MANT_W-1:0] mant
);
   localparam int DEPTH = 1 << FRAC_W;

   logic [MANT_W-1:0] table_w [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         localparam int VAL = lod_pkg::exp_entry(g, FRAC_W, MANT_W);
         assign table_w[g] = MANT_W'(VAL);
      end
   endgenerate

   always_comb mant = table_w[idx];
endmodule

// File: rtl/lod_lin_conv.sv
module lod_lin_conv #(
   parameter int MANT_W    = 10,
   parameter int SHIFT_W   = 5,
   parameter int OUT_W     = 13,
   parameter bit ONES_COMP = 1'b1
) (
   input  logic [MANT_W-1:0]  mant,
   input  logic [SHIFT_W-1:0] shift,
   input  logic               sign,
   output logic [OUT_W-1:0]   sample
);
   localparam int MAG_W = MANT_W + 2;
   localparam int CUT   = MAG_W + 1;

   logic [MAG_W-1:0] full_w;
   logic [MAG_W-1:0] mag_w;
   logic [OUT_W-1:0] ext_w;

   always_comb begin
      full_w = {1'b1, mant, 1'b0};
      if (int'(shift) >= CUT) mag_w = '0;
      else                    mag_w = full_w >> shift;
      ext_w = OUT_W'(mag_w);
   end

   generate
      if (ONES_COMP) begin : g_inv
         always_comb sample = sign ? ~ext_w : ext_w;
      end else begin : g_twos
         always_comb sample = sign ? (~ext_w + 1'b1) : ext_w;
      end
   endgenerate
endmodule

// File: rtl/lod_operator_out.sv
module lod_operator_out #(
   parameter int LS_W      = 12,
   parameter int TL_W      = 6,
   parameter int ENV_W     = 9,
   parameter int TL_SHIFT  = 5,
   parameter int ENV_SHIFT = 3,
   parameter int FRAC_W    = 8,
   parameter int ATT_W     = 13,
   parameter int MANT_W    = 10,
   parameter int OUT_W     = 13,
   parameter bit SATURATE  = 1'b1,
   parameter bit ONES_COMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [11:0]      in_logsin,
   input  logic             in_sign,
   input  logic [5:0]       in_tl,
   input  logic [8:0]       in_env,
   output logic             out_valid,
   output logic [12:0]      out_sample
);
   localparam int SHIFT_W = ATT_W - FRAC_W;
   localparam int MAG_W   = MANT_W + 2;

   generate
      if (ATT_W <= FRAC_W) begin : g_bad_att
         $error("ATT_W must exceed FRAC_W");
      end
      if (OUT_W < MAG_W + 1) begin : g_bad_out
         $error("OUT_W too small for magnitude plus sign");
      end
      if (LS_W != 12 || TL_W != 6 || ENV_W != 9 || OUT_W != 13) begin : g_bad_port
         $error("port widths are fixed at 12/6/9/13");
      end
   endgenerate

   logic [ATT_W-1:0]   att_w;
   logic [MANT_W-1:0]  mant_w;
   logic [OUT_W-1:0]   lin_w;

   logic               s1_valid;
   logic               s1_sign;
   logic [SHIFT_W-1:0] s1_shift;
   logic [MANT_W-1:0]  s1_mant;

   lod_att_sum #(
      .LS_W(LS_W), .TL_W(TL_W), .ENV_W(ENV_W),
      .TL_SHIFT(TL_SHIFT), .ENV_SHIFT(ENV_SHIFT),
      .ATT_W(ATT_W), .SATURATE(SATURATE)
   ) u_sum (
      .logsin(in_logsin), .tl(in_tl), .env(in_env), .att(att_w)
   );

   lod_exp_rom #(.FRAC_W(FRAC_W), .MANT_W(MANT_W)) u_rom (
      .idx(att_w[FRAC_W-1:0]), .mant(mant_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sign  <= 1'b0;
         s1_shift <= '0;
         s1_mant  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_sign  <= in_sign;
            s1_shift <= att_w[ATT_W-1:FRAC_W];
            s1_mant  <= mant_w;
         end
      end
   end

   lod_lin_conv #(
      .MANT_W(MANT_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W), .ONES_COMP(ONES_COMP)
   ) u_lin (
      .mant(s1_mant), .shift(s1_shift), .sign(s1_sign), .sample(lin_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_sample <= lin_w;
      end
   end
endmodule

// File: rtl/lod_operator_out_chk.sv
module lod_operator_out_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [11:0] in_logsin,
   input logic        in_sign,
   input logic [5:0]  in_tl,
   input logic [8:0]  in_env,
   input logic        out_valid,
   input logic [12:0] out_sample
);
   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_sample)); // R8

   AST_PEAK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($signed(out_sample) <= 13'sd4084 && $signed(out_sample) >= -13'sd4085)); // R7

   AST_SIGN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2 && out_valid) |-> (out_sample[12] == $past(in_sign, 2))); // R7

   AST_DEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2 && out_valid && $past(in_env, 2) == 9'h1FF)
      |-> (out_sample == 13'h0000 || out_sample == 13'h1FFF)); // R5

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd2) |-> !out_valid); // R1
endmodule

bind lod_operator_out lod_operator_out_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_logsin(in_logsin),
   .in_sign(in_sign), .in_tl(in_tl), .in_env(in_env),
   .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/lod_operator_out_tb.sv
module lod_operator_out_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] in_logsin = '0;
   logic        in_sign = 1'b0;
   logic [5:0]  in_tl = '0;
   logic [8:0]  in_env = '0;
   logic        out_valid;
   logic [12:0] out_sample;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R9";

   always #2 clk = ~clk;

   lod_operator_out dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_logsin(in_logsin),
      .in_sign(in_sign), .in_tl(in_tl), .in_env(in_env),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   function automatic int ref_sample(int ls, int tl, int env, bit sgn);
      int att, idx, sh, ent, mag;
      att = ls + tl * 32 + env * 8;
      if (att > 8191) att = 8191;
      idx = att % 256;
      sh  = att / 256;
      ent = $rtoi((2.0 ** (real'(255 - idx) / 256.0)) * 1024.0 + 0.5) - 1024;
      mag = (sh >= 13) ? 0 : (((ent + 1024) * 2) >>> sh);
      return sgn ? (-mag - 1) : mag;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model: expected results queued with their output cycle
   int    q_val[$];
   string q_tag[$];
   int    q_due[$];
   int    cyc = 0;
   int    held = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         cyc <= 0;
      end else begin
         cyc <= cyc + 1;
         if (in_valid) begin
            q_val.push_back(ref_sample(int'(in_logsin), int'(in_tl), int'(in_env), in_sign));
            q_tag.push_back(cur_tag);
            q_due.push_back(cyc + 2);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (q_due.size() > 0 && q_due[0] == cyc) begin
            check({q_tag[0], " valid R2"}, int'(out_valid), 1);
            check(q_tag[0], $signed(out_sample), q_val[0]);
            held = q_val[0];
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
            void'(q_due.pop_front());
         end else begin
            check("R2 idle valid", int'(out_valid), 0);
            check("R8 hold", $signed(out_sample), held);
         end
      end
   end

   task automatic drive(int ls, int tl, int env, bit sgn, string tag);
      @(negedge clk);
      cur_tag   = tag;
      in_valid  = 1'b1;
      in_logsin = 12'(ls);
      in_tl     = 6'(tl);
      in_env    = 9'(env);
      in_sign   = sgn;
   endtask

   task automatic idle_scramble(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         in_logsin = 12'($urandom);
         in_tl     = 6'($urandom);
         in_env    = 9'($urandom);
         in_sign   = 1'($urandom);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset valid", int'(out_valid), 0);
      check("R1 reset sample", int'(out_sample), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", int'(out_valid), 0);

      drive(0, 0, 0, 1'b0, "R7 peak positive");
      drive(0, 0, 0, 1'b1, "R7 peak negative");
      idle_scramble(3);
      check("R7 explicit -4085", $signed(out_sample), -4085);
      drive(256, 0, 0, 1'b0, "R4 one shift");
      drive(0, 8, 0, 1'b0, "R3 tl step 8");
      drive(0, 0, 32, 1'b1, "R3 env step 32");
      drive(100, 3, 17, 1'b0, "R3 mixed sum");
      drive(3328, 0, 0, 1'b0, "R5 shift 13");
      drive(3328, 0, 0, 1'b1, "R5 shift 13 negative gives -1");
      drive(4095, 1, 511, 1'b0, "R6 saturate past range");
      drive(4095, 63, 511, 1'b1, "R6 saturate max");
      drive(4095, 0, 511, 1'b0, "R5 deep attenuation");
      idle_scramble(5);
      for (int i = 0; i < 256; i++) drive(i, 0, 0, i[0], "R4 table sweep");
      idle_scramble(4);
      for (int i = 0; i < 400; i++) begin
         if (i % 37 == 5) idle_scramble(2);
         drive(int'($urandom % 4096), int'($urandom % 64), int'($urandom % 512),
               1'($urandom), "R9 stream");
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
      check("R9 all results drained", q_val.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule